// File: doc/BRIEF.md
# Power-Fail Write-Protect and Backup Switchover Sequencer

This block sits beside a battery-backed static memory and decides, from a handful of digitized supply comparator flags, when the memory may be written, when its data outputs must float, and when its array must draw from the backup cell instead of the main rail. The comparators and the analog power switch are outside the block. Four flags report whether the supply is at or above 4.75 V, 4.50 V, 4.25 V and roughly 3.0 V. A build parameter picks the tolerance grade. The tight grade trips write protection at 4.50 V and needs 4.75 V for full operation. The wide grade trips at 4.25 V and needs 4.50 V.

The backup cell is kept isolated on a device that has never been powered. The first time the supply reaches 4.25 V, a sticky latch arms backup operation for good. When the supply sags below the trip level, write protection and output disable follow within a bounded number of clocks. Once the rail is valid again, protection is held for a long recovery interval that is counted in clock cycles. The host's write, chip and output enables are forced inactive for as long as protection holds. Reset stands for a brand-new, never-powered device.

Top module: `nvps_seq`

## Requirements
- R1: After reset, `wprot_o` and `out_dis_o` are 1, and `batt_sel_o` and `backup_armed_o` are 0.
- R2: While `backup_armed_o` is 0, `batt_sel_o` stays 0 for any supply level, including below 3.0 V.
- R3: `backup_armed_o` becomes 1 once the 4.25 V flag has been seen high, and stays 1 until reset.
- R4: If the selected trip flag falls, `wprot_o` is 1 no later than SYNC_STAGES+1 clock edges later, and FAIL_MAX_CYC bounds that latency.
- R5: With TIGHT_TOL=1 the trip flag is the 4.50 V flag and the full-function flag is the 4.75 V flag. With TIGHT_TOL=0 they are the 4.25 V flag and the 4.50 V flag.
- R6: Once the full-function flag is seen while protected, `wprot_o` remains 1 for exactly REC_CYC further cycles of recovery before it clears.
- R7: If the trip flag drops during recovery, recovery is abandoned and the full REC_CYC interval starts over on the next return to full-function level.
- R8: When armed and protected, `batt_sel_o` is 1 while the 3.0 V flag is low, and it returns to 0 after that flag rises.
- R9: While `wprot_o` is 1, `mem_we_no`, `mem_ce_no` and `mem_oe_no` are 1 (active-low, inactive). Otherwise each equals its host input.
- R10: `out_dis_o` equals `wprot_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous active-low reset (fresh device) |
| sup_ge_4v75_i | input | 1 | Supply at or above 4.75 V |
| sup_ge_4v50_i | input | 1 | Supply at or above 4.50 V |
| sup_ge_4v25_i | input | 1 | Supply at or above 4.25 V |
| sup_ge_3v00_i | input | 1 | Supply above the switchover level (about 3.0 V) |
| host_we_ni | input | 1 | Host write enable, active low |
| host_ce_ni | input | 1 | Host chip enable, active low |
| host_oe_ni | input | 1 | Host output enable, active low |
| mem_we_no | output | 1 | Gated write enable to the array |
| mem_ce_no | output | 1 | Gated chip enable to the array |
| mem_oe_no | output | 1 | Gated output enable to the array |
| wprot_o | output | 1 | Write protection active |
| out_dis_o | output | 1 | Data outputs forced to high impedance |
| batt_sel_o | output | 1 | Array powered from backup cell |
| backup_armed_o | output | 1 | One-time backup arming latch |

## Verification
The assertions take the four comparator flags to be mutually consistent, as threshold outputs of one voltage are. A higher-threshold flag is never high while a lower one is low, so reaching the full-function level implies the trip level. The bench upholds this by driving a single supply value in millivolts and deriving all four flags from it. No flag combination is ever set independently. The supply changes only on clock-aligned steps, and each level is held for several cycles so that the synchronizer never sees a one-cycle glitch.

// File: rtl/nvps_pkg.sv
package nvps_pkg;

   typedef enum logic [2:0] {
      NVPS_FRESH  = 3'd0,
      NVPS_NORMAL = 3'd1,
      NVPS_PROT   = 3'd2,
      NVPS_BATT   = 3'd3,
      NVPS_RECOV  = 3'd4
   } nvps_state_e;

   // Levels after variant selection and synchronization
   typedef struct packed {
      logic full;   // full-function level reached
      logic trip;   // above write-protect trip level
      logic arm;    // first-enable level reached
      logic swo;    // above battery switchover level
   } nvps_lvl_t;

   localparam int unsigned NVPS_LVL_W = 4;

endpackage

// File: rtl/nvps_sync.sv
module nvps_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   logic [WIDTH-1:0] stage_q [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("nvps_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= '0;
            else         stage_q[g] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stage_q[g] <= '0;
            else         stage_q[g] <= stage_q[g-1];
         end
      end
   end

   assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/nvps_seal.sv
module nvps_seal (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic arm_i,
   output logic sealed_o
);

   logic sealed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    sealed_q <= 1'b0;
      else if (arm_i) sealed_q <= 1'b1;
   end

   assign sealed_o = sealed_q;

   // R3: once armed, never disarmed
   a_r3_seal_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sealed_q |=> sealed_q);

   // R3: arming only follows a seen first-enable level
   a_r3_seal_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(sealed_q) |-> $past(arm_i));

endmodule

// File: rtl/nvps_rtimer.sv
module nvps_rtimer #(
   parameter int unsigned REC_CYC = 125000
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic done_o
);

   localparam int unsigned CNT_W = $clog2(REC_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   if (REC_CYC < 2) begin : g_bad_rec
      $error("nvps_rtimer: REC_CYC must be at least 2");
   end

   assign done_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 cnt_q <= '0;
      else if (run_i && !done_o)   cnt_q <= cnt_q + 1'b1;
      else                         cnt_q <= '0;
   end

   // R6: the count never passes the recovery interval
   a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= LAST);

   // R7: any pause in running restarts the interval from zero
   a_r7_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/nvps_gate.sv
module nvps_gate #(
   parameter int unsigned LINES = 3
) (
   input  logic             block_i,
   input  logic [LINES-1:0] host_n_i,
   output logic [LINES-1:0] mem_n_o
);

   if (LINES == 0) begin : g_bad_lines
      $error("nvps_gate: LINES must be nonzero");
   end

   for (genvar g = 0; g < LINES; g++) begin : g_line
      assign mem_n_o[g] = host_n_i[g] | block_i;
   end

endmodule

// File: rtl/nvps_seq.sv
module nvps_seq
   import nvps_pkg::*;
#(
   parameter bit          TIGHT_TOL    = 1'b1,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter int unsigned FAIL_MAX_CYC = 4,
   parameter int unsigned REC_CYC      = 125000   // 125 ms at a 1 MHz clock
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sup_ge_4v75_i,
   input  logic sup_ge_4v50_i,
   input  logic sup_ge_4v25_i,
   input  logic sup_ge_3v00_i,
   input  logic host_we_ni,
   input  logic host_ce_ni,
   input  logic host_oe_ni,
   output logic mem_we_no,
   output logic mem_ce_no,
   output logic mem_oe_no,
   output logic wprot_o,
   output logic out_dis_o,
   output logic batt_sel_o,
   output logic backup_armed_o
);

   localparam int unsigned DETECT_CYC = SYNC_STAGES + 1;
   localparam int unsigned GATE_LINES = 3;

   if (DETECT_CYC > FAIL_MAX_CYC) begin : g_bad_fail
      $error("nvps_seq: synchronizer too deep for the fail-detect budget");
   end

   // ---------------- variant selection ----------------
   nvps_lvl_t lvl_raw, lvl_s;

   if (TIGHT_TOL) begin : g_tight
      assign lvl_raw.full = sup_ge_4v75_i;
      assign lvl_raw.trip = sup_ge_4v50_i;
   end else begin : g_wide
      assign lvl_raw.full = sup_ge_4v50_i;
      assign lvl_raw.trip = sup_ge_4v25_i;
   end
   assign lvl_raw.arm = sup_ge_4v25_i;
   assign lvl_raw.swo = sup_ge_3v00_i;

   nvps_sync #(
      .WIDTH  (NVPS_LVL_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (lvl_raw),
      .q_o    (lvl_s)
   );

   // ---------------- freshness latch ----------------
   logic sealed;

   nvps_seal u_seal (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .arm_i    (lvl_s.arm),
      .sealed_o (sealed)
   );

   // ---------------- sequencer ----------------
   nvps_state_e state_q, state_d;
   logic        tmr_run, tmr_done;

   assign tmr_run = (state_q == NVPS_RECOV);

   nvps_rtimer #(
      .REC_CYC (REC_CYC)
   ) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .run_i  (tmr_run),
      .done_o (tmr_done)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         NVPS_FRESH:  if (sealed) state_d = NVPS_PROT;
         NVPS_NORMAL: if (!lvl_s.trip) state_d = NVPS_PROT;
         NVPS_PROT: begin
            if (!lvl_s.swo)      state_d = NVPS_BATT;
            else if (lvl_s.full) state_d = NVPS_RECOV;
         end
         NVPS_BATT:   if (lvl_s.swo) state_d = NVPS_PROT;
         NVPS_RECOV: begin
            if (!lvl_s.trip)   state_d = NVPS_PROT;
            else if (tmr_done) state_d = NVPS_NORMAL;
         end
         default:     state_d = NVPS_PROT;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= NVPS_FRESH;
      else         state_q <= state_d;
   end

   assign wprot_o        = (state_q != NVPS_NORMAL);
   assign out_dis_o      = wprot_o;
   assign batt_sel_o     = (state_q == NVPS_BATT);
   assign backup_armed_o = sealed;

   // ---------------- host gating ----------------
   logic [GATE_LINES-1:0] host_n, mem_n;

   assign host_n = {host_oe_ni, host_ce_ni, host_we_ni};

   nvps_gate #(
      .LINES (GATE_LINES)
   ) u_gate (
      .block_i  (wprot_o),
      .host_n_i (host_n),
      .mem_n_o  (mem_n)
   );

   assign {mem_oe_no, mem_ce_no, mem_we_no} = mem_n;

   // ---------------- assertions ----------------
   // R2: an unarmed device never draws on the backup cell
   a_r2_fresh_no_batt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !sealed |-> !batt_sel_o);

   // R4: a seen trip-level loss protects on the next edge
   a_r4_fail_protect: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !lvl_s.trip |=> wprot_o);

   // R6: protection is released only by an expiring recovery timer
   a_r6_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(wprot_o) |-> $past(tmr_done));

   // R8: switchover back to main supply once the rail is above 3 V
   a_r8_batt_leave: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (batt_sel_o && lvl_s.swo) |=> !batt_sel_o);

   // R9: the array sees no access while protected
   a_r9_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q != NVPS_NORMAL) |-> (mem_we_no && mem_ce_no && mem_oe_no));

endmodule

// File: tb/nvps_seq_tb.sv
module nvps_seq_tb_top;

   localparam time CLK_PERIOD = 10ns;
   localparam int  REC        = 16;
   localparam int  SYNC       = 2;
   localparam int  WATCHDOG   = 20000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   int   vmv = 0;
   logic hwe_n = 1'b1, hce_n = 1'b1, hoe_n = 1'b1;

   logic f475, f450, f425, f300;
   assign f475 = (vmv >= 4750);
   assign f450 = (vmv >= 4500);
   assign f425 = (vmv >= 4250);
   assign f300 = (vmv >= 3000);

   logic mwe [2], mce [2], moe [2], wp [2], od [2], bs [2], ar [2];

   always #(CLK_PERIOD/2) clk = ~clk;

   // index 0: tight tolerance, index 1: wide tolerance
   nvps_seq #(.TIGHT_TOL(1'b1), .SYNC_STAGES(SYNC), .FAIL_MAX_CYC(4), .REC_CYC(REC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .sup_ge_4v75_i(f475), .sup_ge_4v50_i(f450), .sup_ge_4v25_i(f425), .sup_ge_3v00_i(f300),
      .host_we_ni(hwe_n), .host_ce_ni(hce_n), .host_oe_ni(hoe_n),
      .mem_we_no(mwe[0]), .mem_ce_no(mce[0]), .mem_oe_no(moe[0]),
      .wprot_o(wp[0]), .out_dis_o(od[0]), .batt_sel_o(bs[0]), .backup_armed_o(ar[0]));

   nvps_seq #(.TIGHT_TOL(1'b0), .SYNC_STAGES(SYNC), .FAIL_MAX_CYC(4), .REC_CYC(REC)) dut_wide_i (
      .clk_i(clk), .rst_ni(rst_n),
      .sup_ge_4v75_i(f475), .sup_ge_4v50_i(f450), .sup_ge_4v25_i(f425), .sup_ge_3v00_i(f300),
      .host_we_ni(hwe_n), .host_ce_ni(hce_n), .host_oe_ni(hoe_n),
      .mem_we_no(mwe[1]), .mem_ce_no(mce[1]), .mem_oe_no(moe[1]),
      .wprot_o(wp[1]), .out_dis_o(od[1]), .batt_sel_o(bs[1]), .backup_armed_o(ar[1]));

   int checks = 0;
   int fails  = 0;
   string wp_tag = "R6";

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s act=%0b exp=%0b t=%0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- reference model ----------------
   // modes: 0 fresh, 1 normal, 2 protected, 3 battery, 4 recovering
   int       m_mode [2];
   int       m_cnt  [2];
   bit       m_arm  [2];
   bit [3:0] hist [$];   // newest first: {4v75,4v50,4v25,3v00}

   always @(posedge clk or negedge rst_n) begin
      bit [3:0] seen;
      bit full, trip;
      int nm, nc;
      if (!rst_n) begin
         for (int k = 0; k < 2; k++) begin
            m_mode[k] = 0; m_cnt[k] = 0; m_arm[k] = 0;
         end
         hist.delete();
      end else begin
         seen = (hist.size() >= SYNC) ? hist[SYNC-1] : 4'b0000;
         for (int k = 0; k < 2; k++) begin
            full = (k == 0) ? seen[3] : seen[2];
            trip = (k == 0) ? seen[2] : seen[1];
            nm = m_mode[k];
            nc = 0;
            case (m_mode[k])
               0: if (m_arm[k]) nm = 2;
               1: if (!trip) nm = 2;
               2: if (!seen[0]) nm = 3; else if (full) nm = 4;
               3: if (seen[0]) nm = 2;
               4: begin
                  if (m_cnt[k] != REC-1) nc = m_cnt[k] + 1;
                  if (!trip) nm = 2; else if (m_cnt[k] == REC-1) nm = 1;
               end
               default: nm = 2;
            endcase
            if (seen[1]) m_arm[k] = 1;
            m_mode[k] = nm;
            m_cnt[k]  = nc;
         end
         hist.push_front({f475, f450, f425, f300});
         while (hist.size() > SYNC) void'(hist.pop_back());
      end
   end

   always @(negedge clk) begin
      bit ewp;
      if (rst_n) begin
         for (int k = 0; k < 2; k++) begin
            ewp = (m_mode[k] != 1);
            chk(wp_tag, "wprot", wp[k], ewp);
            chk("R10", "out_dis", od[k], ewp);
            chk(m_arm[k] ? "R8" : "R2", "batt_sel", bs[k], m_mode[k] == 3);
            chk("R3", "armed", ar[k], m_arm[k]);
            chk("R9", "mem_we_n", mwe[k], hwe_n | ewp);
            chk("R9", "mem_ce_n", mce[k], hce_n | ewp);
            chk("R9", "mem_oe_n", moe[k], hoe_n | ewp);
         end
      end
   end

   // ---------------- stimulus ----------------
   int pat = 0;

   task automatic step(int n);
      repeat (n) begin
         @(posedge clk);
         #1;
         {hoe_n, hce_n, hwe_n} = 3'(pat);
         pat = pat + 3;
      end
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      fails++;
      $display("FAIL R6 watchdog act=running exp=finished");
      summary();
   end

   initial begin
      vmv = 0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 2; k++) begin
         chk("R1", "reset wprot", wp[k], 1'b1);
         chk("R1", "reset out_dis", od[k], 1'b1);
         chk("R1", "reset batt_sel", bs[k], 1'b0);
         chk("R1", "reset armed", ar[k], 1'b0);
      end

      // R2: fresh device below switchover, then between 3 V and 4.25 V
      step(1); vmv = 2000; step(10);
      @(negedge clk);
      chk("R2", "fresh low batt", bs[0] | bs[1], 1'b0);
      step(1); vmv = 4000; step(8); vmv = 1500; step(8);
      @(negedge clk);
      chk("R2", "fresh dip batt", bs[0] | bs[1], 1'b0);

      // R3: arming at 4.25 V, both grades stay protected there
      vmv = 4300; step(6);
      @(negedge clk);
      chk("R3", "armed", ar[0] & ar[1], 1'b1);

      // R8: switchover below 3 V and back
      step(1); vmv = 2000; step(6);
      @(negedge clk);
      chk("R8", "batt on", bs[0] & bs[1], 1'b1);
      step(1); vmv = 3500; step(6);
      @(negedge clk);
      chk("R8", "batt off", bs[0] | bs[1], 1'b0);
      chk("R3", "still armed", ar[0] & ar[1], 1'b1);

      // R5: 4.6 V is full-function only for the wide grade
      step(1); wp_tag = "R6"; vmv = 4600; step(40);
      @(negedge clk);
      chk("R5", "wide released", wp[1], 1'b0);
      chk("R5", "tight held", wp[0], 1'b1);

      // R6: tight grade recovery, exact release edge
      step(1); vmv = 4800; step(SYNC + 1 + REC - 1);
      @(negedge clk);
      chk("R6", "tight one before release", wp[0], 1'b1);
      step(1);
      @(negedge clk);
      chk("R6", "tight released", wp[0], 1'b0);

      // R9: host pattern runs through while unprotected
      step(16);

      // R4: 4.4 V trips only the tight grade
      step(1); wp_tag = "R4"; vmv = 4400; step(SYNC + 1);
      @(negedge clk);
      chk("R4", "tight protect", wp[0], 1'b1);
      chk("R5", "wide unaffected", wp[1], 1'b0);

      // R7: dip during recovery restarts the interval
      step(1); wp_tag = "R7"; vmv = 4800; step(10);
      vmv = 4400; step(4);
      vmv = 4800; step(SYNC + 1 + REC - 1);
      @(negedge clk);
      chk("R7", "restarted hold", wp[0], 1'b1);
      step(1);
      @(negedge clk);
      chk("R7", "restarted release", wp[0], 1'b0);

      // full power loss and return
      step(1); wp_tag = "R4"; vmv = 0; step(8);
      @(negedge clk);
      chk("R8", "battery on loss", bs[0] & bs[1], 1'b1);
      chk("R4", "protect on loss", wp[0] & wp[1], 1'b1);
      step(1); wp_tag = "R6"; vmv = 5000; step(SYNC + 4 + REC + 4);
      @(negedge clk);
      chk("R6", "normal after return", wp[0] | wp[1], 1'b0);
      step(4);

      summary();
   end

endmodule